// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit data pointers and a small selection register that decides which pointer is active. The core reaches the registers through a simple special-function-register port: an 8-bit address, a write strobe, write data, and read data that follows the address combinationally. A single pair of byte addresses, low and high, always refers to the pointer that is currently selected. The other pointer keeps its value and cannot be seen at those addresses.

The instruction side of the core has its own ports into the block. It can load a 16-bit immediate into the active pointer or increment the active pointer. The active value is always driven on an output, where it is used for external data addressing and for indirect jump bases. The selection register has a bit that always reads as zero, placed directly above the select bit. Because of this, a read-modify-write that adds one to the register flips the selection and leaves the flag bits higher up unchanged.

A second auxiliary register has two bits. One suppresses the address-latch-enable output. The other drives an external-RAM enable.

Top module: `dptr_pair_sfr`

## Requirements
- R1: After reset both pointers are 0000h, the select bit, both flags and both auxiliary bits are 0, and `ptr_active` reads 0000h.
- R2: Bit 0 of the selection register (address A2h) chooses the active pointer. A value of 0 selects pointer 0 and a value of 1 selects pointer 1. `ptr_active` always shows the chosen pointer.
- R3: Address 82h reads and writes the low byte of the active pointer, and address 83h reads and writes its high byte. A byte write leaves the other byte and the inactive pointer unchanged.
- R4: In the selection register, bit 0 is the select bit, bit 3 is a user flag and bit 4 is a control flag, and all three are read/write. Bits 1, 2 and 7:5 always read as 0 and ignore writes. As a result, writing back the read value plus one toggles only bit 0.
- R5: An increment adds 1 to the full 16-bit active pointer. A carry out of the low byte reaches the high byte in the same cycle, and FFFFh wraps to 0000h.
- R6: A load writes the 16-bit immediate into the active pointer only.
- R7: When load and increment are both asserted, the load wins. Either command takes priority over an SFR byte write to 82h or 83h in the same cycle. That byte write is dropped.
- R8: At address 8Eh, bit 0 set to 1 forces `ale_out` low, and bit 0 at 0 lets `ale_out` follow `ale_in`. Bit 1 drives `xram_en`. Bits 7:2 read as 0.
- R9: Reads from any other address return 00h, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_load | input | 1 | Load `ptr_load_val` into the active pointer |
| ptr_load_val | input | 16 | Immediate value for load |
| ptr_active | output | 16 | Current value of the active pointer |
| ale_in | input | 1 | Address-latch-enable from the bus sequencer |
| ale_out | output | 1 | Gated address-latch-enable |
| xram_en | output | 1 | External-RAM enable bit |

## Verification
The bench builds the block with its default parameters: a 16-bit pointer width, the byte addresses 82h and 83h, the selection register at A2h and the auxiliary register at 8Eh. These defaults put the FFFFh wrap and the low-to-high carry within reach of a few writes. They also make the read-plus-one toggle of the selection register observable as a plain byte pattern. Directed sequences cover the wrap, the toggle, and same-cycle collisions between commands and byte writes. A long random phase then mixes all commands across both selections, and a behavioural model compares every output on every clock.

// File: rtl/dptr_pair_sfr.sv
module dptr_pair_sfr #(
  parameter int unsigned PW       = 16,
  parameter logic [7:0]  LO_ADDR  = 8'h82,
  parameter logic [7:0]  HI_ADDR  = 8'h83,
  parameter logic [7:0]  AUX_ADDR = 8'h8E,
  parameter logic [7:0]  SEL_ADDR = 8'hA2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sfr_addr,
  input  logic          sfr_we,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          ptr_inc,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_load_val,
  output logic [PW-1:0] ptr_active,
  input  logic          ale_in,
  output logic          ale_out,
  output logic          xram_en
);

  localparam logic [7:0] SEL_MASK = 8'h19;

  logic [PW-1:0] ptr0_q, ptr1_q;
  logic          sel_q;
  logic [1:0]    flag_q;
  logic          ale_off_q, xram_q;

  wire wr_lo  = sfr_we && (sfr_addr == LO_ADDR);
  wire wr_hi  = sfr_we && (sfr_addr == HI_ADDR);
  wire wr_sel = sfr_we && (sfr_addr == SEL_ADDR);
  wire wr_aux = sfr_we && (sfr_addr == AUX_ADDR);

  logic [PW-1:0] ptr_next;

  assign ptr_active = sel_q ? ptr1_q : ptr0_q;

  always_comb begin
    ptr_next = ptr_active;
    if (ptr_load)      ptr_next = ptr_load_val;
    else if (ptr_inc)  ptr_next = ptr_active + PW'(1);
    else if (wr_lo)    ptr_next[7:0] = sfr_wdata;
    else if (wr_hi)    ptr_next[15:8] = sfr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr0_q    <= '0;
      ptr1_q    <= '0;
      sel_q     <= 1'b0;
      flag_q    <= 2'b00;
      ale_off_q <= 1'b0;
      xram_q    <= 1'b0;
    end else begin
      if (sel_q) ptr1_q <= ptr_next;
      else       ptr0_q <= ptr_next;
      if (wr_sel) begin
        sel_q  <= sfr_wdata[0];
        flag_q <= sfr_wdata[4:3];
      end
      if (wr_aux) begin
        ale_off_q <= sfr_wdata[0];
        xram_q    <= sfr_wdata[1];
      end
    end
  end

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == LO_ADDR)       sfr_rdata = ptr_active[7:0];
    else if (sfr_addr == HI_ADDR)  sfr_rdata = ptr_active[15:8];
    else if (sfr_addr == SEL_ADDR) sfr_rdata = {3'b000, flag_q, 2'b00, sel_q};
    else if (sfr_addr == AUX_ADDR) sfr_rdata = {6'b000000, xram_q, ale_off_q};
  end

  assign ale_out = ale_in & ~ale_off_q;
  assign xram_en = xram_q;

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && !wr_sel) |=> (ptr_active == $past(ptr_active) + PW'(1))); // R5

  AST_LOAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && !wr_sel) |=> (ptr_active == $past(ptr_load_val))); // R6

  AST_INACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q) |=> $stable(ptr1_q)); // R3

  AST_INACTIVE_HELD1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q) |=> $stable(ptr0_q)); // R3

  AST_SEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> ((sfr_addr != SEL_ADDR) || (sfr_rdata == ($past(sfr_wdata) & SEL_MASK)))); // R4

  AST_ALE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_aux && sfr_wdata[0]) |=> !ale_out); // R8

  AST_CMD_OVER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && (wr_lo || wr_hi)) |=> (ptr_active == $past(ptr_active) + PW'(1))); // R7

endmodule

// File: tb/dptr_pair_sfr_tb.sv
`timescale 1ns/1ps
module dptr_pair_sfr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ptr_inc = 1'b0;
  logic        ptr_load = 1'b0;
  logic [15:0] ptr_load_val = 16'h0000;
  logic [15:0] ptr_active;
  logic        ale_in = 1'b0;
  logic        ale_out;
  logic        xram_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_p[2];
  int m_sel, m_flag, m_aoff, m_xram;

  always #2 clk = ~clk;

  dptr_pair_sfr u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_active(ptr_active),
    .ale_in(ale_in), .ale_out(ale_out), .xram_en(xram_en)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      8'h82: return m_p[m_sel] & 8'hFF;
      8'h83: return (m_p[m_sel] >> 8) & 8'hFF;
      8'hA2: return (m_flag << 3) | m_sel;
      8'h8E: return (m_xram << 1) | m_aoff;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      8'h82, 8'h83: return "R3";
      8'hA2: return "R4";
      8'h8E: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model_reset();
    m_p[0] = 0; m_p[1] = 0; m_sel = 0; m_flag = 0; m_aoff = 0; m_xram = 0;
  endtask

  task automatic model_step();
    int s;
    s = m_sel;
    if (ptr_load) m_p[s] = ptr_load_val;
    else if (ptr_inc) m_p[s] = (m_p[s] + 1) & 16'hFFFF;
    else if (sfr_we && sfr_addr == 8'h82) m_p[s] = (m_p[s] & 16'hFF00) | sfr_wdata;
    else if (sfr_we && sfr_addr == 8'h83) m_p[s] = (m_p[s] & 16'h00FF) | (int'(sfr_wdata) << 8);
    if (sfr_we && sfr_addr == 8'hA2) begin
      m_sel = sfr_wdata[0];
      m_flag = (sfr_wdata >> 3) & 3;
    end
    if (sfr_we && sfr_addr == 8'h8E) begin
      m_aoff = sfr_wdata[0];
      m_xram = sfr_wdata[1];
    end
  endtask

  task automatic compare_all();
    chk("R2", ptr_active, m_p[m_sel]);
    chk(rd_tag(sfr_addr), sfr_rdata, exp_rd(sfr_addr));
    chk("R8", ale_out, ale_in & ~m_aoff);
    chk("R8", xram_en, m_xram);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(logic [7:0] a, logic we, logic [7:0] wd,
                       logic inc, logic ld, logic [15:0] lv);
    sfr_addr = a; sfr_we = we; sfr_wdata = wd;
    ptr_inc = inc; ptr_load = ld; ptr_load_val = lv;
  endtask

  task automatic idle_read(logic [7:0] a);
    drive(a, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000);
    step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", ptr_active, 0);
    idle_read(8'hA2);
    chk("R1", sfr_rdata, 0);

    drive(8'h82, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
    drive(8'h83, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
    chk("R3", ptr_active, 16'hFFFF);
    drive(8'h82, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0); step();
    chk("R5", ptr_active, 16'h0000);
    drive(8'h82, 1'b1, 8'hFF, 1'b1, 1'b0, 16'h0); step();
    chk("R7", ptr_active, 16'h0001);
    drive(8'h82, 1'b1, 8'h00, 1'b0, 1'b0, 16'h0); step();
    drive(8'h83, 1'b1, 8'h12, 1'b0, 1'b0, 16'h0); step();
    drive(8'h82, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
    drive(8'h82, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0); step();
    chk("R5", ptr_active, 16'h1300);

    drive(8'hA2, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
    chk("R4", sfr_rdata, 8'h19);
    chk("R2", ptr_active, 16'h0000);
    drive(8'hA2, 1'b1, 8'h1A, 1'b0, 1'b0, 16'h0); step();
    chk("R4", sfr_rdata, 8'h18);
    chk("R2", ptr_active, 16'h1300);
    drive(8'hA2, 1'b1, 8'h19, 1'b0, 1'b0, 16'h0); step();
    drive(8'h82, 1'b0, 8'h00, 1'b1, 1'b1, 16'hBEEF); step();
    chk("R7", ptr_active, 16'hBEEF);
    drive(8'h83, 1'b1, 8'h55, 1'b0, 1'b1, 16'hCAFE); step();
    chk("R6", ptr_active, 16'hCAFE);
    drive(8'hA2, 1'b1, 8'h00, 1'b0, 1'b0, 16'h0); step();
    chk("R6", ptr_active, 16'h1300);

    drive(8'h8E, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); ale_in = 1'b1; step();
    chk("R8", ale_out, 0);
    chk("R8", sfr_rdata, 8'h03);
    drive(8'h8E, 1'b1, 8'h02, 1'b0, 1'b0, 16'h0); step();
    chk("R8", ale_out, 1);
    drive(8'h90, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
    chk("R9", sfr_rdata, 0);
    chk("R9", ptr_active, 16'h1300);
    idle_read(8'hA2);
    chk("R9", sfr_rdata, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: a = 8'h82; 1: a = 8'h83; 2: a = 8'hA2; 3: a = 8'h8E;
        4: a = 8'h82; default: a = 8'($urandom);
      endcase
      drive(a, 1'($urandom), 8'($urandom),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), 16'($urandom));
      ale_in = 1'($urandom);
      if (i % 500 == 7) begin
        drive(8'h82, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
        drive(8'h83, 1'b1, 8'hFF, 1'b0, 1'b0, 16'h0); step();
        drive(8'h82, 1'b0, 8'h00, 1'b1, 1'b0, 16'h0);
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule